// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Controller

This block holds the 8-bit status register of a serial NOR flash device and decides, one decoded instruction at a time, whether a write-type command may proceed. An SPI front end gives it single-cycle strobes for write enable, write disable, status read, status write, program, sector erase, block erase and chip erase. It also gives it a target address and the byte carried by a status write. A busy-timer model returns a one-cycle completion pulse when the operation it started has finished.

Each strobe produces exactly one registered response one cycle later. Write-type strobes give an accept pulse or an ignore pulse. A status read gives a valid pulse with the register value as it stood when the read was issued. An accepted status write, program or erase raises the busy flag, which stays high until the completion pulse arrives. The write-protect pin, the register's lock bit and the quad-mode bit together decide whether the status register can be rewritten. The block-protect code protects a power-of-two count of 64 KB blocks counted down from the top of the array.

Top module: `flash_status_guard`

## Requirements
- R1: After reset, `status_q` is 0x00, `quad_mode` is 0 and no response pulse is high. Bit layout from bit 7 to bit 0 is: lock bit, quad bit, protect code [3:0], write-enable latch (bit 1), busy (bit 0).
- R2: Write enable sets bit 1 and write disable clears it. Each returns an accept pulse.
- R3: A status write, program, sector erase, block erase or chip erase issued while bit 1 is 0 returns an ignore pulse and leaves `status_q` unchanged.
- R4: An accepted status write, program or erase sets bit 0 and leaves bit 1 set. The next `op_done` pulse clears both bits. An `op_done` pulse while bit 0 is 0 changes nothing.
- R5: While bit 0 is 1, every strobe except status read returns an ignore pulse and changes nothing.
- R6: An accepted status write copies `wrsr_data[7:2]` into bits 7..2. Bits 1..0 of the data byte are not written into the register.
- R7: A status write is ignored when bit 7 is 1, `wp_n` is 0 and bit 6 is 0. With `wp_n` at 1, or with bit 6 at 1, the status write is allowed.
- R8: With a non-zero protect code c, the top N blocks of 64 KB are protected. N is 2^(c-1), limited to the block count, and code 15 protects every block. A program or an erase whose block index (`cmd_addr[ADDR_W-1:16]`) falls in the protected range is ignored.
- R9: Chip erase is accepted only when the protect code is 0.
- R10: A status read returns `rd_valid` one cycle later, with `rd_data` equal to `status_q` as it was when the read was issued. This includes while busy.
- R11: `quad_mode` follows bit 6 of the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_rdsr | input | 1 | Status-read strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_prog | input | 1 | Program strobe |
| cmd_se | input | 1 | Sector-erase strobe |
| cmd_be | input | 1 | Block-erase strobe |
| cmd_ce | input | 1 | Chip-erase strobe |
| cmd_addr | input | ADDR_W | Target address for program and erase |
| wrsr_data | input | 8 | Byte carried by a status write |
| wp_n | input | 1 | Write-protect pin level, active low |
| op_done | input | 1 | Completion pulse from the busy timer |
| status_q | output | 8 | Live status register |
| quad_mode | output | 1 | 1 when the WP/HOLD pins serve as data lines |
| cmd_ok | output | 1 | Accept pulse |
| cmd_ignored | output | 1 | Ignore pulse |
| rd_valid | output | 1 | Status-read data valid |
| rd_data | output | 8 | Status-read data |

## Verification
The bench checks the edges of the protect decode. For code 1 and code 3 it probes the lowest protected block and the block just below it. It also checks code 15 at block 0. A decoder that is off by one would accept a program into the top block or refuse the one below. The bench confirms that the quad bit lifts the pin lock, and that a locked status write keeps the write-enable latch set. A design that ignores the quad bit would wrongly ignore that status write; one that clears the latch on rejection would show bit 1 as 0. It also issues a status read and other strobes while busy, and an idle completion pulse. A design that let commands through while busy, or cleared the latch on a stray completion pulse, would show a different status byte than expected.

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
  parameter int ADDR_W    = 20,
  parameter int BLK_SHIFT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_rdsr,
  input  logic              cmd_wrsr,
  input  logic              cmd_prog,
  input  logic              cmd_se,
  input  logic              cmd_be,
  input  logic              cmd_ce,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        wrsr_data,
  input  logic              wp_n,
  input  logic              op_done,
  output logic [7:0]        status_q,
  output logic              quad_mode,
  output logic              cmd_ok,
  output logic              cmd_ignored,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  localparam int BLKW = ADDR_W - BLK_SHIFT;
  localparam int NBLK = 1 << BLKW;
  localparam logic [BLKW:0] NBLK_V = (BLKW+1)'(NBLK);

  logic       srwd, qe, wel, wip;
  logic [3:0] bp;

  assign status_q  = {srwd, qe, bp, wel, wip};
  assign quad_mode = qe;

  logic unused_bits;
  assign unused_bits = ^{cmd_addr[BLK_SHIFT-1:0], wrsr_data[1:0]};

  logic sr_locked;
  assign sr_locked = srwd & ~wp_n & ~qe;

  logic [BLKW:0] prot_cnt;
  logic [BLKW:0] blk_idx;
  logic          prot_hit;
  assign blk_idx = {1'b0, cmd_addr[ADDR_W-1:BLK_SHIFT]};

  always_comb begin
    prot_cnt = '0;
    if (bp != 4'd0) begin
      if (bp == 4'hF || int'(bp) > BLKW + 1) prot_cnt = NBLK_V;
      else prot_cnt = (BLKW+1)'(1) << (bp - 4'd1);
      if (prot_cnt > NBLK_V) prot_cnt = NBLK_V;
    end
  end

  assign prot_hit = (prot_cnt != '0) && (blk_idx >= NBLK_V - prot_cnt);

  logic ok_now, bad_now, start_op, wel_set, wel_clr, ld_sr;

  always_comb begin
    ok_now = 1'b0; bad_now = 1'b0; start_op = 1'b0;
    wel_set = 1'b0; wel_clr = 1'b0; ld_sr = 1'b0;
    if (cmd_wren) begin
      if (wip) bad_now = 1'b1;
      else begin ok_now = 1'b1; wel_set = 1'b1; end
    end else if (cmd_wrdi) begin
      if (wip) bad_now = 1'b1;
      else begin ok_now = 1'b1; wel_clr = 1'b1; end
    end else if (cmd_wrsr) begin
      if (wip || !wel || sr_locked) bad_now = 1'b1;
      else begin ok_now = 1'b1; start_op = 1'b1; ld_sr = 1'b1; end
    end else if (cmd_prog || cmd_se || cmd_be) begin
      if (wip || !wel || prot_hit) bad_now = 1'b1;
      else begin ok_now = 1'b1; start_op = 1'b1; end
    end else if (cmd_ce) begin
      if (wip || !wel || bp != 4'd0) bad_now = 1'b1;
      else begin ok_now = 1'b1; start_op = 1'b1; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srwd <= 1'b0; qe <= 1'b0; bp <= '0; wel <= 1'b0; wip <= 1'b0;
      cmd_ok <= 1'b0; cmd_ignored <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      cmd_ok      <= ok_now;
      cmd_ignored <= bad_now;
      rd_valid    <= cmd_rdsr;
      if (cmd_rdsr) rd_data <= status_q;
      if (op_done && wip) begin
        wip <= 1'b0;
        wel <= 1'b0;
      end
      if (wel_set) wel <= 1'b1;
      if (wel_clr) wel <= 1'b0;
      if (start_op) wip <= 1'b1;
      if (ld_sr) {srwd, qe, bp} <= wrsr_data[7:2];
    end
  end

  AST_BUSY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[0]) |-> cmd_ok); // R4
  AST_IGNORE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ignored && !$past(op_done)) |-> $stable(status_q)); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && status_q[0]) |=> (status_q[1:0] == 2'b00)); // R4
  AST_PIN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && status_q[7] && !wp_n && !status_q[6]) |=> !cmd_ok); // R7
  AST_CHIP_ERASE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ce && status_q[5:2] != 4'd0) |=> !cmd_ok); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[0] && (cmd_wren || cmd_wrdi || cmd_wrsr || cmd_prog || cmd_se || cmd_be || cmd_ce)) |=> cmd_ignored); // R5
  AST_READ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rdsr |=> (rd_valid && rd_data == $past(status_q))); // R10
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ok && cmd_ignored)); // R3
endmodule

// File: tb/tb_flash_status_guard.sv
module tb_flash_status_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_rdsr = 0, cmd_wrsr = 0;
  logic cmd_prog = 0, cmd_se = 0, cmd_be = 0, cmd_ce = 0;
  logic [19:0] cmd_addr = '0;
  logic [7:0]  wrsr_data = '0;
  logic wp_n = 1'b1, op_done = 1'b0;
  logic [7:0] status_q, rd_data;
  logic quad_mode, cmd_ok, cmd_ignored, rd_valid;

  always #4 clk = ~clk;

  flash_status_guard #(.ADDR_W(20), .BLK_SHIFT(16)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_rdsr(cmd_rdsr), .cmd_wrsr(cmd_wrsr), .cmd_prog(cmd_prog), .cmd_se(cmd_se),
    .cmd_be(cmd_be), .cmd_ce(cmd_ce), .cmd_addr(cmd_addr), .wrsr_data(wrsr_data),
    .wp_n(wp_n), .op_done(op_done), .status_q(status_q), .quad_mode(quad_mode),
    .cmd_ok(cmd_ok), .cmd_ignored(cmd_ignored), .rd_valid(rd_valid), .rd_data(rd_data));

  typedef enum int {OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_PROG, OP_SE, OP_BE, OP_CE} op_e;
  typedef enum int {K_OK, K_IGN, K_RD} kind_e;
  typedef struct { kind_e kind; logic [7:0] data; logic [7:0] st; string tag; } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  logic m_srwd = 0, m_qe = 0, m_wel = 0, m_wip = 0;
  logic [3:0] m_bp = 0;

  function automatic logic [7:0] mst();
    return {m_srwd, m_qe, m_bp, m_wel, m_wip};
  endfunction

  function automatic bit prot(input logic [3:0] c, input int blk);
    int n;
    if (c == 0) return 0;
    n = (c == 15 || c > 5) ? 16 : (1 << (c - 1));
    return blk >= 16 - n;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic issue(input op_e op, input int blk, input logic [7:0] d, input string tag);
    exp_t e;
    bit ok;
    @(negedge clk);
    cmd_addr = 20'(blk) << 16;
    wrsr_data = d;
    e.tag = tag; e.data = 8'h00;
    ok = 0;
    case (op)
      OP_WREN: begin cmd_wren = 1; ok = !m_wip; if (ok) m_wel = 1; end
      OP_WRDI: begin cmd_wrdi = 1; ok = !m_wip; if (ok) m_wel = 0; end
      OP_RDSR: begin cmd_rdsr = 1; e.data = mst(); end
      OP_WRSR: begin
        cmd_wrsr = 1;
        ok = !m_wip && m_wel && !(m_srwd && !wp_n && !m_qe);
        if (ok) begin {m_srwd, m_qe, m_bp} = d[7:2]; m_wip = 1; end
      end
      OP_PROG, OP_SE, OP_BE: begin
        if (op == OP_PROG) cmd_prog = 1; else if (op == OP_SE) cmd_se = 1; else cmd_be = 1;
        ok = !m_wip && m_wel && !prot(m_bp, blk);
        if (ok) m_wip = 1;
      end
      OP_CE: begin cmd_ce = 1; ok = !m_wip && m_wel && m_bp == 0; if (ok) m_wip = 1; end
      default: ;
    endcase
    e.kind = (op == OP_RDSR) ? K_RD : (ok ? K_OK : K_IGN);
    e.st = mst();
    q.push_back(e);
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_rdsr, cmd_wrsr, cmd_prog, cmd_se, cmd_be, cmd_ce} = '0;
  endtask

  task automatic done(input string tag);
    @(negedge clk);
    op_done = 1;
    if (m_wip) begin m_wip = 0; m_wel = 0; end
    @(negedge clk);
    op_done = 0;
    chk(tag, status_q, mst());
  endtask

  always @(negedge clk) begin
    if (rst_n && (cmd_ok || cmd_ignored || rd_valid)) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected response: actual=%b%b%b expected=none", cmd_ok, cmd_ignored, rd_valid);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " response"}, {5'd0, cmd_ok, cmd_ignored, rd_valid},
            {5'd0, e.kind == K_OK, e.kind == K_IGN, e.kind == K_RD});
        if (e.kind == K_RD) chk({e.tag, " read data"}, rd_data, e.data);
        chk({e.tag, " status"}, status_q, e.st);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset status", status_q, 8'h00);
    chk("R1 reset responses", {5'd0, cmd_ok, cmd_ignored, rd_valid}, 8'h00);
    chk("R11 reset quad", {7'd0, quad_mode}, 8'h00);
    rst_n = 1;
    issue(OP_PROG, 0, 8'h00, "R3 program without latch");
    issue(OP_WRSR, 0, 8'h3C, "R3 status write without latch");
    issue(OP_CE, 0, 8'h00, "R3 chip erase without latch");
    issue(OP_RDSR, 0, 8'h00, "R10 idle read");
    issue(OP_WREN, 0, 8'h00, "R2 write enable");
    issue(OP_WRDI, 0, 8'h00, "R2 write disable");
    issue(OP_WREN, 0, 8'h00, "R2 write enable again");
    issue(OP_PROG, 3, 8'h00, "R4 program accepted");
    issue(OP_RDSR, 0, 8'h00, "R10 read while busy");
    issue(OP_WREN, 0, 8'h00, "R5 enable while busy");
    issue(OP_WRDI, 0, 8'h00, "R5 disable while busy");
    issue(OP_PROG, 2, 8'h00, "R5 program while busy");
    done("R4 completion clears");
    done("R4 idle completion");
    issue(OP_WREN, 0, 8'h00, "R6 enable");
    issue(OP_WRSR, 0, 8'hFF, "R6 status write low bits masked");
    done("R6 completion");
    chk("R11 quad on", {7'd0, quad_mode}, 8'h01);
    wp_n = 0;
    issue(OP_WREN, 0, 8'h00, "R7 enable");
    issue(OP_WRSR, 0, 8'h84, "R7 quad bypasses pin lock");
    done("R7 completion");
    chk("R11 quad off", {7'd0, quad_mode}, 8'h00);
    issue(OP_WREN, 0, 8'h00, "R7 enable locked");
    issue(OP_WRSR, 0, 8'h00, "R7 pin lock ignores");
    issue(OP_RDSR, 0, 8'h00, "R7 latch kept after lock");
    wp_n = 1;
    issue(OP_WRSR, 0, 8'h04, "R7 pin high allows");
    done("R7 completion two");
    issue(OP_WREN, 0, 8'h00, "R8 enable");
    issue(OP_PROG, 15, 8'h00, "R8 code1 top block protected");
    issue(OP_SE, 14, 8'h00, "R8 code1 block below open");
    done("R8 completion");
    issue(OP_WREN, 0, 8'h00, "R9 enable");
    issue(OP_CE, 0, 8'h00, "R9 chip erase refused");
    issue(OP_WRSR, 0, 8'h0C, "R8 set code3");
    done("R8 completion two");
    issue(OP_WREN, 0, 8'h00, "R8 enable two");
    issue(OP_BE, 12, 8'h00, "R8 code3 lowest protected");
    issue(OP_PROG, 11, 8'h00, "R8 code3 block below open");
    done("R8 completion three");
    issue(OP_WREN, 0, 8'h00, "R8 enable three");
    issue(OP_WRSR, 0, 8'h3C, "R8 set code15");
    done("R8 completion four");
    issue(OP_WREN, 0, 8'h00, "R8 enable four");
    issue(OP_PROG, 0, 8'h00, "R8 code15 block0 protected");
    issue(OP_WRSR, 0, 8'h00, "R9 clear protect");
    done("R9 completion");
    issue(OP_WREN, 0, 8'h00, "R9 enable");
    issue(OP_CE, 0, 8'h00, "R9 chip erase accepted");
    done("R9 completion two");
    repeat (3) @(negedge clk);
    chk("R10 all responses seen", 8'(q.size()), 8'h00);
    summary();
    $finish;
  end
endmodule